// File: doc/BRIEF.md
# Interrupt Enable and Event Flag Register

This block is the interrupt control register of a small microcontroller core. It is eight bits wide. It holds a master enable, an enable for the peripheral group, one enable for each of three local sources, and one sticky flag for each of those sources. The three local sources are a timer overflow strobe, an external edge strobe, and a change on four port pins. The external edge is already qualified outside this block.

Software reaches the register over a simple register bus. It answers at two bank-mirrored addresses, and both map to one storage. The block also watches reads of the port input address. Such a read reloads the snapshot used by the pin-change detector, so a read acknowledges the mismatch. The port pins pass through a two-flop synchronizer before they are compared. The block drives one combined interrupt request to the core.

The change flag has no defined power-up value. A parameter selects the variant: `RESET_CHANGE_FLAG=1` (the default) clears it on reset so simulation is deterministic, and `0` builds it with no reset.

Top module: `icr_top`

## Requirements
- R1: While reset is asserted and directly after it, the register reads 0x00 and `irqOut` is low. Bits 7..1 are always cleared by reset; bit 0 is cleared by reset only in the default variant.
- R2: The register is read and written at bus addresses 0x0B and 0x8B, which share one storage. A write to any other address leaves the register unchanged. A read of any other address returns 0x00.
- R3: The bit layout is fixed. Bit 7 is the master enable, bit 6 the peripheral enable, bit 5 the timer enable, bit 4 the external enable and bit 3 the change enable. Bit 2 is the timer flag, bit 1 the external flag and bit 0 the change flag. A `timerOvf` pulse sets bit 2 and an `extEdge` pulse sets bit 1 on the next clock edge, whatever the enables hold.
- R4: Flags are sticky. Hardware never clears them, and only a register write with a 0 in the flag position clears a flag.
- R5: `irqOut` equals master AND ((timer enable AND timer flag) OR (external enable AND external flag) OR (change enable AND change flag) OR (peripheral enable AND `periphReq`)). With the master enable at 0, `irqOut` stays low.
- R6: When any of the four port pins differs from its last snapshot, bit 0 reads 1 on the third clock edge after the pin change, and not before.
- R7: A bus read at address 0x06 or 0x86 loads the synchronized pins into the snapshot. After that, a write of 0 clears bit 0, and bit 0 stays 0 while the pins hold still.
- R8: When a set event and a register write that clears the same flag fall in one cycle, the flag ends up at 1.
- R9: With the peripheral enable at 0, a high `periphReq` does not raise `irqOut`, even when the master enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data; combinational, 0x00 when this register is not addressed |
| timerOvf | input | 1 | One-cycle timer overflow event |
| extEdge | input | 1 | One-cycle qualified external edge event |
| portPins | input | 4 | Asynchronous upper port pins 7..4 |
| periphReq | input | 1 | OR of the masked peripheral-group flags |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to produce is the pin-change flag racing software. In that case the pins still differ from the snapshot, so a clearing write has to lose. Only after a port read has reloaded the snapshot may a clearing write take effect. The stimulus moves the pins, then reads the register in each of the next three cycles to find the exact edge where the flag appears. It then issues a clearing write while the mismatch is still present, reads the mirrored port address, and clears again. The timer and write collision is driven in one cycle by a task that raises the strobe together with the write.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int RegW  = 8;
  localparam int PortW = 4;
  localparam int NumFlags = 3;

  localparam int BitGie  = 7;
  localparam int BitPeie = 6;
  localparam int BitTmrE = 5;
  localparam int BitExtE = 4;
  localparam int BitChgE = 3;
  localparam int BitTmrF = 2;
  localparam int BitExtF = 1;
  localparam int BitChgF = 0;

  typedef struct packed {
    logic regWr;
    logic regRd;
    logic portAck;
  } busStb_t;
endpackage

// File: rtl/icr_ctrl.sv
module icr_ctrl
  import icr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [6:0]  REG_ADDR  = 7'h0B,
  parameter logic [6:0]  PORT_ADDR = 7'h06
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStb_t           stb
);
  localparam int MatchW = 7;

  logic regHit;
  logic portHit;

  // Bank bit (MSB) ignored: 0x0B/0x8B and 0x06/0x86 alias.
  assign regHit  = (busAddr[MatchW-1:0] == REG_ADDR);
  assign portHit = (busAddr[MatchW-1:0] == PORT_ADDR);

  always_comb begin
    stb.regWr   = busWrEn && regHit;
    stb.regRd   = busRdEn && regHit;
    stb.portAck = busRdEn && portHit;
  end
endmodule

// File: rtl/icr_datapath.sv
module icr_datapath
  import icr_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter bit RESET_CHANGE_FLAG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStb_t          stb,
  input  logic [RegW-1:0]  busWrData,
  input  logic             timerOvf,
  input  logic             extEdge,
  input  logic [PortW-1:0] portPins,
  input  logic             periphReq,
  output logic [RegW-1:0]  busRdData,
  output logic             irqOut
);
  localparam int EnW = RegW - NumFlags;

  // Pin synchronizer
  logic [PortW-1:0] syncPipe [SYNC_STAGES];
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= portPins;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  logic [PortW-1:0] syncPins;
  logic [PortW-1:0] lastSample;
  logic             portMismatch;

  assign syncPins = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastSample <= '0;
    else if (stb.portAck) lastSample <= syncPins;
  end

  assign portMismatch = |(syncPins ^ lastSample);

  // Enable bits
  logic [EnW-1:0] enQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else if (stb.regWr) enQ <= busWrData[RegW-1:NumFlags];
  end

  // Sticky flags: the hardware set wins over a clearing write
  logic [NumFlags-1:0] setVec;
  logic [NumFlags-1:0] flagQ;
  logic [NumFlags-1:0] flagNext;

  assign setVec[BitTmrF] = timerOvf;
  assign setVec[BitExtF] = extEdge;
  assign setVec[BitChgF] = portMismatch;

  genvar f;
  generate
    for (f = 0; f < NumFlags; f++) begin : gFlag
      assign flagNext[f] = (stb.regWr ? busWrData[f] : flagQ[f]) | setVec[f];
      if (f == BitChgF && !RESET_CHANGE_FLAG) begin : gNoRst
        always_ff @(posedge clk) flagQ[f] <= flagNext[f];
      end else begin : gRst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) flagQ[f] <= 1'b0;
          else flagQ[f] <= flagNext[f];
        end
      end
    end
  endgenerate

  logic [RegW-1:0] regVal;
  logic gie, peie, tmrE, extE, chgE;

  assign regVal = {enQ, flagQ};
  assign gie    = regVal[BitGie];
  assign peie   = regVal[BitPeie];
  assign tmrE   = regVal[BitTmrE];
  assign extE   = regVal[BitExtE];
  assign chgE   = regVal[BitChgE];

  assign busRdData = stb.regRd ? regVal : '0;
  assign irqOut = gie && ((tmrE && flagQ[BitTmrF]) || (extE && flagQ[BitExtF]) ||
                          (chgE && flagQ[BitChgF]) || (peie && periphReq));

  // Assertions
  assert_timer_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> flagQ[BitTmrF]);

  assert_ext_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[BitExtF] && !(stb.regWr && !busWrData[BitExtF])) |=> flagQ[BitExtF]);

  assert_gie_masks_R5: assert property (@(posedge clk) disable iff (!rstN)
    !regVal[BitGie] |-> !irqOut);

  assert_change_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    portMismatch |=> flagQ[BitChgF]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && !busWrData[BitTmrF] && timerOvf) |=> flagQ[BitTmrF]);

  assert_peie_masks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!peie && !flagQ[BitTmrF] && !flagQ[BitExtF] && !flagQ[BitChgF]) |-> !irqOut);
endmodule

// File: rtl/icr_top.sv
module icr_top
  import icr_pkg::*;
#(
  parameter int          ADDR_W            = 8,
  parameter logic [6:0]  REG_ADDR          = 7'h0B,
  parameter logic [6:0]  PORT_ADDR         = 7'h06,
  parameter int          SYNC_STAGES       = 2,
  parameter bit          RESET_CHANGE_FLAG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              busRdEn,
  output logic [7:0]        busRdData,
  input  logic              timerOvf,
  input  logic              extEdge,
  input  logic [3:0]        portPins,
  input  logic              periphReq,
  output logic              irqOut
);
  busStb_t stb;

  icr_ctrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PORT_ADDR(PORT_ADDR)
  ) uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .stb(stb)
  );

  icr_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .RESET_CHANGE_FLAG(RESET_CHANGE_FLAG)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busWrData(busWrData),
    .timerOvf(timerOvf), .extEdge(extEdge), .portPins(portPins),
    .periphReq(periphReq), .busRdData(busRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_icr_top.sv
`timescale 1ns/1ps
module tb_icr_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       timerOvf = 1'b0;
  logic       extEdge = 1'b0;
  logic [3:0] portPins = '0;
  logic       periphReq = 1'b0;
  logic       irqOut;

  always #10 clk = ~clk;

  icr_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .timerOvf(timerOvf), .extEdge(extEdge), .portPins(portPins),
    .periphReq(periphReq), .irqOut(irqOut)
  );

  typedef struct {
    bit         isIrq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t scoreQ[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;

  // Monitor: compares in the middle of the cycle, away from the active edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = scoreQ.pop_front();
      act = it.isIrq ? {7'b0, irqOut} : busRdData;
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: %s actual=0x%02h expected=0x%02h",
                 it.tag, it.isIrq ? "irqOut" : "busRdData", act, it.exp);
      end
    end
  end

  task automatic idleBus();
    busWrEn = 1'b0; busRdEn = 1'b0; timerOvf = 1'b0; extEdge = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1; idleBus();
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    step(); busAddr = a; busWrData = d; busWrEn = 1'b1;
  endtask

  task automatic busWriteTimer(input logic [7:0] a, input logic [7:0] d);
    step(); busAddr = a; busWrData = d; busWrEn = 1'b1; timerOvf = 1'b1;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    step(); busAddr = a; busRdEn = 1'b1;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic expectIrq(input bit e, input string tag);
    item_t it;
    step();
    it.isIrq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic pulseTimer(); step(); timerOvf = 1'b1; endtask
  task automatic pulseExt();   step(); extEdge = 1'b1;  endtask
  task automatic setPins(input logic [3:0] p); step(); portPins = p; endtask
  task automatic setPeriph(input bit v); step(); periphReq = v; endtask

  task automatic finish();
    step(); step();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: the register and irqOut while reset is held
    repeat (2) @(posedge clk);
    #1; busAddr = 8'h0B; busRdEn = 1'b1;
    begin
      item_t it;
      it.isIrq = 1'b0; it.exp = 8'h00; it.tag = "R1 in reset";
      scoreQ.push_back(it);
    end
    @(posedge clk); #1; idleBus(); rstN = 1'b1;

    // R1: state after reset
    busRead(8'h0B, 8'h00, "R1 after reset");
    expectIrq(1'b0, "R1 irq after reset");

    // R2: the two mirrored addresses
    busWrite(8'h8B, 8'hF8);
    busRead(8'h0B, 8'hF8, "R2 write 0x8B read 0x0B");
    busWrite(8'h0B, 8'hE8);
    busRead(8'h8B, 8'hE8, "R2 write 0x0B read 0x8B");
    busWrite(8'h1B, 8'h00);
    busRead(8'h0B, 8'hE8, "R2 foreign write ignored");
    busRead(8'h1B, 8'h00, "R2 foreign read zero");

    // R3: flags set with every enable off
    busWrite(8'h0B, 8'h00);
    pulseTimer();
    busRead(8'h0B, 8'h04, "R3 timer flag bit2");
    expectIrq(1'b0, "R5 masked without enables");
    pulseExt();
    busRead(8'h0B, 8'h06, "R3 external flag bit1");

    // R4: sticky flags, cleared only by writing 0
    repeat (5) step();
    busRead(8'h0B, 8'h06, "R4 flags held");
    busWrite(8'h0B, 8'h02);
    busRead(8'h0B, 8'h02, "R4 clear timer flag only");
    busWrite(8'h0B, 8'h00);
    busRead(8'h0B, 8'h00, "R4 clear external flag");

    // R5: request equation and master mask
    busWrite(8'h0B, 8'hA0);
    expectIrq(1'b0, "R5 enable without flag");
    pulseTimer();
    busRead(8'h0B, 8'hA4, "R5 flag with enables");
    expectIrq(1'b1, "R5 timer request");
    busWrite(8'h0B, 8'h24);
    expectIrq(1'b0, "R5 master off masks");
    busWrite(8'h0B, 8'h00);

    // R8: set beats a clearing write in the same cycle
    busWrite(8'h0B, 8'h04);
    busWriteTimer(8'h0B, 8'h00);
    busRead(8'h0B, 8'h04, "R8 set wins");
    busWrite(8'h0B, 8'h00);
    busRead(8'h0B, 8'h00, "R8 later clear");

    // R6: latency of the pin-change flag
    setPins(4'b0101);
    busRead(8'h0B, 8'h00, "R6 edge 1 no flag");
    busRead(8'h0B, 8'h00, "R6 edge 2 no flag");
    busRead(8'h0B, 8'h01, "R6 edge 3 flag");

    // R7: clear refused while mismatch persists, accepted after port read
    busWrite(8'h0B, 8'h00);
    busRead(8'h0B, 8'h01, "R7 clear before port read");
    busRead(8'h86, 8'h00, "R7 port read returns zero here");
    busWrite(8'h0B, 8'h00);
    busRead(8'h0B, 8'h00, "R7 clear after port read");
    repeat (4) step();
    busRead(8'h0B, 8'h00, "R7 stays cleared");

    // R6 again with change enable, through the other port alias
    busWrite(8'h0B, 8'h88);
    setPins(4'b1101);
    step(); step(); step();
    busRead(8'h0B, 8'h89, "R6 second change");
    expectIrq(1'b1, "R5 change request");
    busRead(8'h06, 8'h00, "R7 port read alias 0x06");
    busWrite(8'h0B, 8'h00);
    busRead(8'h0B, 8'h00, "R7 clear after alias read");

    // R9: peripheral group gate
    busWrite(8'h0B, 8'h80);
    setPeriph(1'b1);
    expectIrq(1'b0, "R9 peripheral gate closed");
    busWrite(8'h0B, 8'hC0);
    expectIrq(1'b1, "R9 peripheral gate open");
    busWrite(8'h0B, 8'h40);
    expectIrq(1'b0, "R5 master off with peripheral");
    setPeriph(1'b0);

    // R5: external source request
    busWrite(8'h0B, 8'h90);
    expectIrq(1'b0, "R5 external no flag");
    pulseExt();
    busRead(8'h0B, 8'h92, "R3 external flag with enable");
    expectIrq(1'b1, "R5 external request");

    finish();
  end
endmodule